// File: doc/BRIEF.md
# Output Bit-Error Signature Extractor

This block turns pairs of words into a small bit-error fingerprint. Each pair holds the output word a circuit under test is expected to produce for one stimulus and the word it actually produced. Four features come from each pair. Two are plain counts: errors where a 0 became a 1, and errors where a 1 became a 0. The other two add up a position weight for each error of each direction. Two words with the same number of errors in different places therefore give different features.

The block adds the features of a fixed number of accepted pairs, called a bin. When the last pair of a bin has been taken in, it raises a one-cycle strobe that carries the four bin totals. A second, independent path takes one inlier/outlier flag per bin from a downstream classifier. It reduces a fixed number of those flags, called a batch, to a single majority verdict. Word width, bin length and batch length are parameters.

Top module: `errsig_top`

## Requirements
- R1: For each accepted pair, the rising-error count is the number of bit positions where the expected bit is 0 and the measured bit is 1.
- R2: For each accepted pair, the falling-error count is the number of bit positions where the expected bit is 1 and the measured bit is 0.
- R3: The rising weight of a pair is the sum of (index + 1) over its rising-error positions, where index 0 is the least significant bit.
- R4: The falling weight of a pair is the sum of (index + 1) over its falling-error positions, with the same indexing as R3.
- R5: A pair is accepted on a rising clock edge where `inValid` and `inReady` are both 1. After every `BIN_LEN` accepted pairs, `binDone` is 1 for exactly the cycle after the edge that accepted the last pair. In that cycle the four feature outputs hold the sums of R1 to R4 over exactly those pairs. Each bin starts again from zero. The sums never wrap, even when every bit flips in every pair at full width.
- R6: Word values presented while `inValid` is 0 have no effect on any bin total.
- R7: A batch verdict reports outlier (`verdictOutlier` = 1) only when strictly more than half of the batch's flags are outlier (`flagOutlier` = 1). A tie reports inlier (0).
- R8: After every `BATCH_LEN` flags accepted while `flagValid` is 1, `verdictValid` is 1 for exactly the cycle after the edge that took the last flag. At all other times it is 0.
- R9: `flagOutlier` values presented while `flagValid` is 0 are not counted in any batch.
- R10: Synchronous reset (`rst` = 1 at a clock edge) clears `binDone`, `verdictValid` and `inReady`. It also discards any partly filled bin and any partly counted batch.
- R11: `inReady` is 1 from the first clock edge after `rst` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Word pair present |
| inReady | output | 1 | Block accepts word pairs |
| expWord | input | WORD_W | Expected output word |
| measWord | input | WORD_W | Measured output word |
| binDone | output | 1 | One-cycle strobe: bin totals valid |
| riseCount | output | CNT_W | Bin total of rising errors |
| fallCount | output | CNT_W | Bin total of falling errors |
| riseWeight | output | WGT_W | Bin total of rising position weights |
| fallWeight | output | WGT_W | Bin total of falling position weights |
| flagValid | input | 1 | Per-bin flag present |
| flagOutlier | input | 1 | Per-bin flag: 1 = outlier, 0 = inlier |
| verdictValid | output | 1 | One-cycle strobe: batch verdict valid |
| verdictOutlier | output | 1 | Batch verdict: 1 = outlier, 0 = inlier |

## Verification
The bench builds the block with 32-bit words, a bin of 5 pairs and a batch of 4 flags. The even batch length makes a two-to-two tie possible, so the strict-majority rule of R7 can be checked against both neighbouring tallies. With five all-flipping 32-bit words a bin reaches 160 errors and a weight of 2640, which reaches the upper limit of both feature widths. The narrow word also keeps random patterns dense enough that every bit position shows up in the weight sums.

// File: rtl/errsig_pkg.sv
package errsig_pkg;

  // strobes from control to datapath, one per accepted word pair
  typedef struct packed {
    logic load;   // first pair of a bin: overwrite accumulators
    logic accum;  // later pair of a bin: add to accumulators
  } accCtl_t;

  // bits needed to hold values 0..maxVal
  function automatic int bitsFor(input longint maxVal);
    int n;
    n = 1;
    while ((longint'(1) << n) <= maxVal) n++;
    return n;
  endfunction

endpackage

// File: rtl/errsig_datapath.sv
module errsig_datapath
  import errsig_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 8,
  parameter int WGT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  accCtl_t           ctl,
  input  logic [WORD_W-1:0] expWord,
  input  logic [WORD_W-1:0] measWord,
  output logic [CNT_W-1:0]  riseCount,
  output logic [CNT_W-1:0]  fallCount,
  output logic [WGT_W-1:0]  riseWeight,
  output logic [WGT_W-1:0]  fallWeight
);

  localparam int NDIR   = 2;  // 0 = rising, 1 = falling
  localparam int WCNT_W = bitsFor(longint'(WORD_W));
  localparam int WWGT_W = bitsFor(longint'(WORD_W) * longint'(WORD_W + 1) / 2);

  logic [WORD_W-1:0] flipMask [NDIR];
  logic [WCNT_W-1:0] wordCnt  [NDIR];
  logic [WWGT_W-1:0] wordWgt  [NDIR];
  logic [CNT_W-1:0]  accCnt   [NDIR];
  logic [WGT_W-1:0]  accWgt   [NDIR];

  // bitwise AND of the measured word against the expected word or its inverse
  assign flipMask[0] = measWord & ~expWord;
  assign flipMask[1] = ~measWord & expWord;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_comb begin
      wordCnt[d] = WCNT_W'($countones(flipMask[d]));
      wordWgt[d] = '0;
      for (int i = 0; i < WORD_W; i++) begin
        if (flipMask[d][i]) wordWgt[d] = wordWgt[d] + WWGT_W'(i + 1);
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        accCnt[d] <= '0;
        accWgt[d] <= '0;
      end else if (ctl.load) begin
        accCnt[d] <= CNT_W'(wordCnt[d]);
        accWgt[d] <= WGT_W'(wordWgt[d]);
      end else if (ctl.accum) begin
        accCnt[d] <= accCnt[d] + CNT_W'(wordCnt[d]);
        accWgt[d] <= accWgt[d] + WGT_W'(wordWgt[d]);
      end
    end

    // every counted flip adds at least 1 and at most WORD_W to the weight
    assert_weight_floor_R3: assert property (@(posedge clk) disable iff (rst)
      longint'(accWgt[d]) >= longint'(accCnt[d]))
      else $error("weight below count, dir %0d", d);
    assert_weight_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
      longint'(accWgt[d]) <= longint'(WORD_W) * longint'(accCnt[d]))
      else $error("weight above WORD_W*count, dir %0d", d);
  end

  // matching words produce no error of either kind
  assert_match_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (expWord == measWord) |-> (wordCnt[0] == '0 && wordWgt[0] == '0))
    else $error("rising error on matching words");
  assert_match_clean_R2: assert property (@(posedge clk) disable iff (rst)
    (expWord == measWord) |-> (wordCnt[1] == '0 && wordWgt[1] == '0))
    else $error("falling error on matching words");

  assign riseCount  = accCnt[0];
  assign fallCount  = accCnt[1];
  assign riseWeight = accWgt[0];
  assign fallWeight = accWgt[1];

endmodule

// File: rtl/errsig_ctrl.sv
module errsig_ctrl
  import errsig_pkg::*;
#(
  parameter int BIN_LEN = 5
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output logic    inReady,
  output accCtl_t ctl,
  output logic    binDone
);

  localparam int POS_W = (BIN_LEN > 1) ? $clog2(BIN_LEN) : 1;

  logic [POS_W-1:0] binPos;
  logic             accept;
  logic             lastInBin;
  logic             readyReg;

  assign accept    = inValid && readyReg;
  assign lastInBin = (int'(binPos) == BIN_LEN - 1);
  assign inReady   = readyReg;

  always_comb begin
    ctl.load  = accept && (binPos == '0);
    ctl.accum = accept && (binPos != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      readyReg <= 1'b0;
      binPos   <= '0;
      binDone  <= 1'b0;
    end else begin
      readyReg <= 1'b1;
      binDone  <= accept && lastInBin;
      if (accept) binPos <= lastInBin ? '0 : binPos + 1'b1;
    end
  end

  assert_pos_range_R5: assert property (@(posedge clk) disable iff (rst)
    int'(binPos) < BIN_LEN)
    else $error("bin position out of range");
  assert_done_follows_accept_R5: assert property (@(posedge clk) disable iff (rst)
    binDone |-> $past(inValid && inReady))
    else $error("bin closed without an accepted pair");
  assert_ready_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> inReady)
    else $error("not ready after reset release");

endmodule

// File: rtl/errsig_vote.sv
module errsig_vote
  import errsig_pkg::*;
#(
  parameter int BATCH_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic flagValid,
  input  logic flagOutlier,
  output logic verdictValid,
  output logic verdictOutlier
);

  localparam int TAL_W = bitsFor(longint'(BATCH_LEN));

  logic [TAL_W-1:0] seenCnt;
  logic [TAL_W-1:0] outCnt;
  logic [TAL_W-1:0] outNext;
  logic             batchEnd;

  assign outNext  = outCnt + TAL_W'(flagOutlier);
  assign batchEnd = (int'(seenCnt) == BATCH_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seenCnt        <= '0;
      outCnt         <= '0;
      verdictValid   <= 1'b0;
      verdictOutlier <= 1'b0;
    end else begin
      verdictValid <= 1'b0;
      if (flagValid) begin
        if (batchEnd) begin
          verdictValid   <= 1'b1;
          verdictOutlier <= (2 * int'(outNext)) > BATCH_LEN;
          seenCnt        <= '0;
          outCnt         <= '0;
        end else begin
          seenCnt <= seenCnt + 1'b1;
          outCnt  <= outNext;
        end
      end
    end
  end

  assert_verdict_follows_flag_R8: assert property (@(posedge clk) disable iff (rst)
    verdictValid |-> $past(flagValid))
    else $error("verdict without a flag");
  assert_tally_bound_R7: assert property (@(posedge clk) disable iff (rst)
    int'(outCnt) <= int'(seenCnt) && int'(seenCnt) < BATCH_LEN)
    else $error("vote tally out of range");

endmodule

// File: rtl/errsig_top.sv
module errsig_top
  import errsig_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BIN_LEN   = 5,
  parameter int BATCH_LEN = 3,
  parameter int CNT_W     = bitsFor(longint'(BIN_LEN) * longint'(WORD_W)),
  parameter int WGT_W     = bitsFor(longint'(BIN_LEN) * longint'(WORD_W) * longint'(WORD_W + 1) / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] expWord,
  input  logic [WORD_W-1:0] measWord,
  output logic              binDone,
  output logic [CNT_W-1:0]  riseCount,
  output logic [CNT_W-1:0]  fallCount,
  output logic [WGT_W-1:0]  riseWeight,
  output logic [WGT_W-1:0]  fallWeight,
  input  logic              flagValid,
  input  logic              flagOutlier,
  output logic              verdictValid,
  output logic              verdictOutlier
);

  accCtl_t accCtl;

  errsig_ctrl #(.BIN_LEN(BIN_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .ctl(accCtl), .binDone(binDone)
  );

  errsig_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W), .WGT_W(WGT_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(accCtl), .expWord(expWord), .measWord(measWord),
    .riseCount(riseCount), .fallCount(fallCount),
    .riseWeight(riseWeight), .fallWeight(fallWeight)
  );

  errsig_vote #(.BATCH_LEN(BATCH_LEN)) u_vote (
    .clk(clk), .rst(rst), .flagValid(flagValid), .flagOutlier(flagOutlier),
    .verdictValid(verdictValid), .verdictOutlier(verdictOutlier)
  );

endmodule

// File: tb/sim_errsig_top.sv
module sim_errsig_top;

  localparam int W     = 32;
  localparam int BIN   = 5;
  localparam int BATCH = 4;
  localparam int CW    = 8;
  localparam int GW    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, flagValid = 1'b0, flagOutlier = 1'b0;
  logic [W-1:0] expWord = '0, measWord = '0;
  logic inReady, binDone, verdictValid, verdictOutlier;
  logic [CW-1:0] riseCount, fallCount;
  logic [GW-1:0] riseWeight, fallWeight;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  errsig_top #(.WORD_W(W), .BIN_LEN(BIN), .BATCH_LEN(BATCH)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .expWord(expWord), .measWord(measWord), .binDone(binDone),
    .riseCount(riseCount), .fallCount(fallCount),
    .riseWeight(riseWeight), .fallWeight(fallWeight),
    .flagValid(flagValid), .flagOutlier(flagOutlier),
    .verdictValid(verdictValid), .verdictOutlier(verdictOutlier)
  );

  function automatic int refCnt(input logic [W-1:0] m);
    return $countones(m);
  endfunction

  function automatic int refWgt(input logic [W-1:0] m);
    int s = 0;
    for (int i = 0; i < W; i++) if (m[i]) s += i + 1;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid  = 1'b0;
      expWord  = $urandom;
      measWord = $urandom;
      flagValid   = 1'b0;
      flagOutlier = 1'b1;
    end
  endtask

  // push one bin of pairs, optionally with idle gaps, and check the totals
  task automatic runBin(input logic [W-1:0] e [BIN], input logic [W-1:0] m [BIN],
                        input bit gaps, input string tag);
    int rc = 0, fc = 0, rw = 0, fw = 0;
    for (int k = 0; k < BIN; k++) begin
      @(negedge clk);
      inValid = 1'b1; expWord = e[k]; measWord = m[k];
      rc += refCnt(m[k] & ~e[k]); fc += refCnt(e[k] & ~m[k]);
      rw += refWgt(m[k] & ~e[k]); fw += refWgt(e[k] & ~m[k]);
      @(negedge clk);
      inValid = 1'b0; expWord = $urandom; measWord = $urandom;
      if (k == 0) check({"R5 no strobe mid-bin ", tag}, int'(binDone), 0);
      if (k < BIN - 1 && gaps) begin
        idle(1 + ($urandom % 3));
      end
    end
    check({"R5 strobe ", tag}, int'(binDone), 1);
    check({"R1 rise count ", tag}, int'(riseCount), rc);
    check({"R2 fall count ", tag}, int'(fallCount), fc);
    check({"R3 rise weight ", tag}, int'(riseWeight), rw);
    check({"R4 fall weight ", tag}, int'(fallWeight), fw);
    @(negedge clk);
    check({"R5 strobe one cycle ", tag}, int'(binDone), 0);
  endtask

  task automatic runBatch(input bit f [BATCH], input bit gaps, input string tag);
    int n = 0;
    for (int k = 0; k < BATCH; k++) begin
      @(negedge clk);
      flagValid = 1'b1; flagOutlier = f[k]; n += int'(f[k]);
      @(negedge clk);
      flagValid = 1'b0; flagOutlier = 1'b1;
      if (k < BATCH - 1) check({"R8 no verdict early ", tag}, int'(verdictValid), 0);
      if (k < BATCH - 1 && gaps) idle(1 + ($urandom % 2));
    end
    check({"R8 verdict strobe ", tag}, int'(verdictValid), 1);
    check({"R7 verdict ", tag}, int'(verdictOutlier), (2 * n > BATCH) ? 1 : 0);
    @(negedge clk);
    check({"R8 verdict one cycle ", tag}, int'(verdictValid), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] e [BIN];
    logic [W-1:0] m [BIN];
    bit f [BATCH];
    void'($urandom(32'd20240611));

    // reset state (R10)
    repeat (3) @(negedge clk);
    check("R10 inReady in reset", int'(inReady), 0);
    check("R10 binDone in reset", int'(binDone), 0);
    check("R10 verdictValid in reset", int'(verdictValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 ready after release", int'(inReady), 1);

    // directed: every bit rises in every pair -> maximum totals
    for (int k = 0; k < BIN; k++) begin e[k] = '0; m[k] = '1; end
    runBin(e, m, 0, "all rise max");
    // every bit falls
    for (int k = 0; k < BIN; k++) begin e[k] = '1; m[k] = '0; end
    runBin(e, m, 0, "all fall max");
    // matching words
    for (int k = 0; k < BIN; k++) begin e[k] = $urandom; m[k] = e[k]; end
    runBin(e, m, 0, "match");
    // same single-flip count at different positions: top bit vs bit 0
    for (int k = 0; k < BIN; k++) begin
      e[k] = 32'h8000_0001; m[k] = (k % 2) ? 32'h0000_0001 : 32'h8000_0000;
    end
    runBin(e, m, 0, "position weight");

    // random bins, some with idle gaps carrying junk data (R6)
    for (int b = 0; b < 20; b++) begin
      for (int k = 0; k < BIN; k++) begin
        e[k] = $urandom;
        m[k] = e[k] ^ ($urandom & $urandom);
      end
      runBin(e, m, b[0], b[0] ? "R6 random gaps" : "random");
    end

    // votes: tie, one above, none, all (R7), with ignored junk flags (R9)
    f = '{1, 0, 1, 0}; runBatch(f, 0, "tie");
    f = '{1, 1, 0, 1}; runBatch(f, 0, "three of four");
    f = '{0, 0, 0, 0}; runBatch(f, 1, "R9 none with junk");
    f = '{1, 1, 1, 1}; runBatch(f, 0, "all");
    f = '{0, 1, 0, 0}; runBatch(f, 1, "R9 one with junk");
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < BATCH; k++) f[k] = bit'($urandom % 2);
      runBatch(f, 1, "random");
    end

    // reset mid-bin and mid-batch discards partial state (R10)
    @(negedge clk);
    inValid = 1'b1; expWord = '0; measWord = '1;
    flagValid = 1'b1; flagOutlier = 1'b1;
    repeat (2) @(negedge clk);
    inValid = 1'b0; flagValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R10 inReady cleared", int'(inReady), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 ready again", int'(inReady), 1);
    for (int k = 0; k < BIN; k++) begin e[k] = 32'h0000_00F0; m[k] = 32'h0000_0F00; end
    runBin(e, m, 0, "R10 fresh bin after reset");
    f = '{0, 0, 1, 0}; runBatch(f, 0, "R10 fresh batch after reset");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule